// File: doc/BRIEF.md
# Converter Continuous-Read Serial Port

This block is the device-side serial port of a sigma-delta converter, reduced to the continuous-read path. A converter core signals each finished conversion with a one-cycle pulse and a 24-bit result. The host talks to the port over three wires: chip select, serial clock and data in. A single combined output line carries both the ready indication and the serial data.

A command byte enters continuous-read mode. Once the mode is active, every finished conversion is placed in the output register without any read command. The output line drops low to show that a word is waiting. The host then applies serial clocks to shift the word out. A word can be taken only once. A newer conversion replaces a word that has not been fully read.

The host leaves the mode with a second command byte, accepted only while a word is waiting. It can also leave the mode by holding data in high for a long run of clocks, which resets the interface. The serial pins are sampled through synchronizers in the system clock domain. All other command bytes are ignored.

Top module: `adc_cread_port`

## Requirements
- R1: After reset `dout_rdy` is 1 and `cread_active` is 0.
- R2: Command bytes are taken from `din` MSB first, one bit per rising `sclk` edge while `cs_n` is low, in groups of 8. The byte 0x5C sets `cread_active` when the mode is off.
- R3: While `cread_active` is 1, a `conv_done` pulse loads `conv_data`, and `dout_rdy` goes to 0 one clock later. The line stays 0 until the first falling `sclk` edge.
- R4: Each falling `sclk` edge presents the next result bit on `dout_rdy`, MSB first, for 24 bits. After the 24th rising edge the line returns to 1.
- R5: A word is read only once. Further `sclk` clocks with no new conversion leave `dout_rdy` at 1.
- R6: A `conv_done` pulse that arrives while a word is unread or partly read discards that word. The line goes back to 0, and the next read returns the new word from its MSB.
- R7: The byte 0x58 clears `cread_active` only while a word is waiting (loaded and not fully read). With no word waiting it is ignored.
- R8: 40 consecutive ones sampled on `din` clear `cread_active`, return `dout_rdy` to 1 and restart byte alignment. A zero before the 40th one restarts the count.
- R9: `conv_done` has no effect while `cread_active` is 0.
- R10: While `cs_n` is high, `sclk` edges are ignored and both the byte bit count and the ones run count are cleared.
- R11: In continuous-read mode, command bytes other than 0x58 (including 0x5C) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| conv_data | input | 24 | Conversion result, valid with `conv_done` |
| sclk | input | 1 | Host serial clock, idles high |
| cs_n | input | 1 | Host chip select, active low |
| din | input | 1 | Host serial data in |
| dout_rdy | output | 1 | Combined ready (low) and serial data out |
| cread_active | output | 1 | Continuous-read mode is on |

## Verification
On every cycle, the assertions check the following:
- a conversion in mode pulls the line low on the next clock;
- a port with no word waiting holds the line high;
- a waiting, unshifted word keeps the line low;
- the mode only ends through an exit byte with a word waiting, or through an interface reset;
- the ones count never reaches its limit;
- chip-select high clears both counters.

Only the bench scenarios can show the following:
- the MSB-first order of a whole shifted word;
- read-once behaviour over a second burst;
- replacement of a partly read word;
- immunity of a split command byte and a split ones run to chip-select toggling;
- re-entry into the mode right after an interface reset.

// File: rtl/adc_cread_pkg.sv
package adc_cread_pkg;

  localparam logic [7:0] CMD_ENTER = 8'h5C;
  localparam logic [7:0] CMD_EXIT  = 8'h58;

  typedef enum logic [1:0] {
    OS_IDLE  = 2'd0,
    OS_READY = 2'd1,
    OS_SHIFT = 2'd2
  } out_state_e;

endpackage

// File: rtl/adc_cread_sync.sv
module adc_cread_sync #(
  parameter int            NUM     = 3,
  parameter int            STAGES  = 2,
  parameter logic [NUM-1:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] async_i,
  output logic [NUM-1:0] sync_o,
  output logic [NUM-1:0] rise_o,
  output logic [NUM-1:0] fall_o
);

  for (genvar g = 0; g < NUM; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    logic [STAGES:0] pipe_d;

    always_comb pipe_d = {pipe_q[STAGES-1:0], async_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL[g]}};
      else        pipe_q <= pipe_d;
    end

    assign sync_o[g] = pipe_q[STAGES-1];
    assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[g] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
  end

endmodule

// File: rtl/adc_cread_cmd.sv
module adc_cread_cmd
  import adc_cread_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int ONES_LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_low_i,
  input  logic rise_i,
  input  logic din_i,
  input  logic pending_i,
  output logic mode_o,
  output logic iface_rst_o
);

  localparam int BCNT_W = $clog2(CMD_W);
  localparam int ONES_W = $clog2(ONES_LIMIT + 1);

  logic [CMD_W-1:0]  sh_q, sh_d, byte_w;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic              mode_q, mode_d;
  logic              irst_q, irst_d;

  assign byte_w = {sh_q[CMD_W-2:0], din_i};

  always_comb begin
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    ones_d = ones_q;
    mode_d = mode_q;
    irst_d = 1'b0;
    if (!cs_low_i) begin
      bcnt_d = '0;
      ones_d = '0;
    end else if (rise_i) begin
      if (din_i && (ones_q == ONES_W'(ONES_LIMIT - 1))) begin
        ones_d = '0;
        bcnt_d = '0;
        mode_d = 1'b0;
        irst_d = 1'b1;
      end else begin
        ones_d = din_i ? (ones_q + ONES_W'(1)) : '0;
        sh_d   = byte_w;
        if (bcnt_q == BCNT_W'(CMD_W - 1)) begin
          bcnt_d = '0;
          if (!mode_q && (byte_w == CMD_ENTER[CMD_W-1:0]))
            mode_d = 1'b1;
          else if (mode_q && pending_i && (byte_w == CMD_EXIT[CMD_W-1:0]))
            mode_d = 1'b0;
        end else begin
          bcnt_d = bcnt_q + BCNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      ones_q <= '0;
      mode_q <= 1'b0;
      irst_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      ones_q <= ones_d;
      mode_q <= mode_d;
      irst_q <= irst_d;
    end
  end

  assign mode_o      = mode_q;
  assign iface_rst_o = irst_q;

  p_ones_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q < ONES_W'(ONES_LIMIT));

  p_cs_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low_i |=> (bcnt_q == '0) && (ones_q == '0));

  p_exit_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mode_q) && !irst_q) |-> $past(pending_i));

  p_irst_ends_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irst_q |-> !mode_q);

endmodule

// File: rtl/adc_cread_out.sv
module adc_cread_out
  import adc_cread_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fall_i,
  input  logic              rise_i,
  output logic              dout_o,
  output logic              pending_o
);

  localparam int CNT_W = $clog2(DATA_W);

  out_state_e        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              dout_q, dout_d;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    left_d = left_q;
    if (!enable_i || flush_i) begin
      st_d = OS_IDLE;
    end else if (load_i) begin
      st_d = OS_READY;
      sh_d = data_i;
    end else begin
      case (st_q)
        OS_READY: if (fall_i) begin
          st_d   = OS_SHIFT;
          left_d = CNT_W'(DATA_W - 1);
        end
        OS_SHIFT: begin
          if (rise_i && (left_q == '0)) begin
            st_d = OS_IDLE;
          end else if (fall_i && (left_q != '0)) begin
            sh_d   = {sh_q[DATA_W-2:0], 1'b0};
            left_d = left_q - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
    if (st_d == OS_SHIFT) dout_d = sh_d[DATA_W-1];
    else                  dout_d = (st_d == OS_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OS_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      dout_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      dout_q <= dout_d;
    end
  end

  assign dout_o    = dout_q;
  assign pending_o = (st_q != OS_IDLE);

  p_load_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && enable_i && !flush_i) |=> !dout_q);

  p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == OS_READY && enable_i && !flush_i && !load_i && !fall_i) |=> !dout_q);

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && !(load_i && enable_i)) |=> dout_q);

  p_shift_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == OS_SHIFT && enable_i && !flush_i && !load_i && !fall_i && !rise_i)
      |=> $stable(dout_q));

endmodule

// File: rtl/adc_cread_port.sv
module adc_cread_port
  import adc_cread_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CMD_W      = 8,
  parameter int ONES_LIMIT = 40,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout_rdy,
  output logic              cread_active
);

  localparam int NSIG = 3;
  localparam int I_SCLK = 0;
  localparam int I_CSN  = 1;
  localparam int I_DIN  = 2;

  logic [1:0]      rst_pipe_q;
  logic            rst_int_n;
  logic [NSIG-1:0] pin_s, pin_rise, pin_fall;
  logic            cs_low, sclk_rise, sclk_fall;
  logic            mode, iface_rst, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  adc_cread_sync #(
    .NUM    (NSIG),
    .STAGES (SYNC_STG),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .async_i({din, cs_n, sclk}),
    .sync_o (pin_s),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign cs_low    = ~pin_s[I_CSN];
  assign sclk_rise = pin_rise[I_SCLK] & cs_low;
  assign sclk_fall = pin_fall[I_SCLK] & cs_low;

  adc_cread_cmd #(
    .CMD_W     (CMD_W),
    .ONES_LIMIT(ONES_LIMIT)
  ) u_cmd (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_low_i   (cs_low),
    .rise_i     (sclk_rise),
    .din_i      (pin_s[I_DIN]),
    .pending_i  (pending),
    .mode_o     (mode),
    .iface_rst_o(iface_rst)
  );

  adc_cread_out #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable_i (mode),
    .flush_i  (iface_rst),
    .load_i   (conv_done),
    .data_i   (conv_data),
    .fall_i   (sclk_fall),
    .rise_i   (sclk_rise),
    .dout_o   (dout_rdy),
    .pending_o(pending)
  );

  assign cread_active = mode;

  p_no_conv_outside_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (conv_done && !mode) |=> dout_rdy);

  p_unused_edges_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cs_low && !conv_done) |=> $stable(pending) || !mode);

endmodule

// File: tb/adc_cread_port_tb.sv
module adc_cread_port_tb;

  localparam int HP = 8;

  logic        clk, rst_n, conv_done, sclk, cs_n, din;
  logic [23:0] conv_data;
  logic        dout_rdy, cread_active;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [23:0] exp_q[$];
  logic [23:0] got_q[$];

  adc_cread_port u_dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .sclk(sclk), .cs_n(cs_n), .din(din), .dout_rdy(dout_rdy),
    .cread_active(cread_active)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic conv(input logic [23:0] v);
    @(negedge clk);
    conv_done = 1'b1;
    conv_data = v;
    exp_q.delete();
    exp_q.push_back(v);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic send_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = bits[i]; wclk(HP);
      sclk = 1'b1; wclk(HP);
    end
    din = 1'b0;
  endtask

  task automatic read_n(input int n, output logic [23:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; din = 1'b0; wclk(HP);
      v = {v[22:0], dout_rdy};
      sclk = 1'b1; wclk(HP);
    end
  endtask

  task automatic read_word();
    logic [23:0] v;
    read_n(24, v);
    got_q.push_back(v);
  endtask

  task automatic cs_toggle();
    cs_n = 1'b1; wclk(6);
    cs_n = 1'b0; wclk(6);
  endtask

  // monitor: compares each word read by the host with the scoreboard entry
  initial begin
    forever begin
      @(negedge clk);
      if (got_q.size() > 0) begin
        logic [23:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "R4 word without conversion", g, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(g == e, "R4/R6 shifted word", g, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    rst_n = 1'b0; conv_done = 1'b0; conv_data = '0;
    sclk = 1'b1; cs_n = 1'b1; din = 1'b0;
    wclk(5);
    rst_n = 1'b1;
    wclk(6);
    chk(dout_rdy == 1'b1, "R1 reset dout_rdy", dout_rdy, 1);
    chk(cread_active == 1'b0, "R1 reset mode", cread_active, 0);
    cs_n = 1'b0; wclk(6);

    // R9: conversion outside the mode
    conv(24'h111111);
    exp_q.delete();
    wclk(3);
    chk(dout_rdy == 1'b1, "R9 conv ignored outside mode", dout_rdy, 1);

    // R10: split command byte across chip-select toggle
    send_bits(64'h5, 4);
    cs_toggle();
    send_bits(64'hC, 4);
    wclk(4);
    chk(cread_active == 1'b0, "R10 byte alignment reset by cs", cread_active, 0);
    cs_toggle();

    // R2: enter mode
    send_bits(64'h5C, 8);
    wclk(4);
    chk(cread_active == 1'b1, "R2 enter byte 0x5C", cread_active, 1);

    // R3/R4: load and read one word
    conv(24'hA5C3F1);
    wclk(1);
    chk(dout_rdy == 1'b0, "R3 ready low after conv", dout_rdy, 0);
    wclk(20);
    chk(dout_rdy == 1'b0, "R3 ready held low", dout_rdy, 0);
    read_word();
    chk(dout_rdy == 1'b1, "R4 line high after word", dout_rdy, 1);

    // R5: read once
    read_n(24, v);
    chk(v == 24'hFFFFFF, "R5 second burst returns idle ones", v, 24'hFFFFFF);

    // R6: partial read then new conversion
    conv(24'h123456);
    read_n(10, v);
    chk(v[9:0] == 10'h048, "R4 partial bits MSB first", v[9:0], 10'h048);
    conv(24'hFEDCBA);
    wclk(2);
    chk(dout_rdy == 1'b0, "R6 reload drives line low", dout_rdy, 0);
    read_word();
    cs_toggle();

    // R6: unread word replaced
    conv(24'h0F0F0F);
    wclk(10);
    conv(24'h00FF00);
    read_word();

    // R10: sclk ignored while cs_n high
    conv(24'hC0FFEE);
    cs_n = 1'b1; wclk(6);
    for (int i = 0; i < 24; i++) begin
      sclk = 1'b0; wclk(HP); sclk = 1'b1; wclk(HP);
    end
    cs_n = 1'b0; wclk(6);
    chk(dout_rdy == 1'b0, "R10 sclk ignored with cs_n high", dout_rdy, 0);
    read_word();

    // R11 / R7: other bytes, and exit with no word waiting
    send_bits(64'h3C, 8);
    send_bits(64'h5C, 8);
    wclk(4);
    chk(cread_active == 1'b1, "R11 other bytes ignored in mode", cread_active, 1);
    send_bits(64'h58, 8);
    wclk(4);
    chk(cread_active == 1'b1, "R7 exit ignored with no word waiting", cread_active, 1);

    // R7: exit while a word waits
    conv(24'h5A5A5A);
    exp_q.delete();
    send_bits(64'h58, 8);
    wclk(4);
    chk(cread_active == 1'b0, "R7 exit with word waiting", cread_active, 0);
    chk(dout_rdy == 1'b1, "R7 line high after exit", dout_rdy, 1);

    // R10: ones run split by chip select
    send_bits(64'h5C, 8);
    wclk(4);
    chk(cread_active == 1'b1, "R2 re-enter", cread_active, 1);
    send_bits('1, 30);
    cs_toggle();
    send_bits('1, 30);
    cs_toggle();
    chk(cread_active == 1'b1, "R10 ones count cleared by cs", cread_active, 1);

    // R8: 39 ones, a zero, 39 ones does not reset
    send_bits('1, 39);
    send_bits(64'h0, 1);
    send_bits('1, 39);
    wclk(4);
    chk(cread_active == 1'b1, "R8 39 ones no reset", cread_active, 1);
    cs_toggle();

    // R8: 40 ones reset while a word waits
    conv(24'h777777);
    exp_q.delete();
    send_bits('1, 40);
    wclk(4);
    chk(cread_active == 1'b0, "R8 40 ones ends mode", cread_active, 0);
    chk(dout_rdy == 1'b1, "R8 line high after reset", dout_rdy, 1);
    send_bits(64'h5C, 8);
    wclk(4);
    chk(cread_active == 1'b1, "R8 alignment restarts after reset", cread_active, 1);
    conv(24'h9ABCDE);
    read_word();

    wclk(20);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule